// File: doc/BRIEF.md
# Dual-role SPI port with fault flags

This block is a byte-wide SPI port driven through four small registers. It can act as the bus master, making its own serial clock from the system clock, or as a slave that follows a clock, a data line and an active-low select coming from elsewhere. Every frame is full duplex: each bit sent out is matched by one bit taken in. A frame is 1 to 8 bits long, most significant bit first, in any of the four clock-polarity and clock-phase combinations.

Software writes a byte to the data address. In master mode this starts a frame. In slave mode it preloads the byte the slave will send. When the frame ends, the received bits are copied into a separate receive register and a completion flag is raised. Status flags report an attempted write during a frame, a reception that replaced data not yet read, and a select line pulled low by another master while this port was master. In that last case the port gives up the bus by leaving master mode.

Top module: `spi_node`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the config register (address 1) reads 0x07, the rate register (address 2) reads 0x00, and all three output enables are low.
- R2: Control register bits are: 0 enable, 1 master, 2 busy (read-only), 3 selected (read-only), 4 done, 5 write collision, 6 overrun, 7 mode fault. Config register bits are: [2:0] length code, 3 clock polarity, 4 clock phase. Address 3 is data: a write goes to transmit, a read returns the receive register.
- R3: In master mode, with enable and master set, a data write made while the port is not busy starts a frame. The serial clock first toggles rate+1 cycles after the write cycle and then toggles every rate+1 cycles. Busy falls, and done and the receive register update, exactly 2·(length code+1)·(rate+1) cycles after the write.
- R4: The master serial clock rests at the clock-polarity level when no frame is running, and returns to that level after the last edge.
- R5: A frame carries length code+1 bits. It sends data bits [code] down to [0] and receives bits right-aligned, with the upper bits read as zero. With clock phase 0, input is sampled on the leading clock edge and output changes on the trailing edge. With clock phase 1, output changes on the leading edge and input is sampled on the trailing edge.
- R6: A data write while busy is dropped, sets the write-collision flag, and leaves the running frame and its result unchanged.
- R7: A frame that completes while the previous received byte is unread sets the overrun flag, and the new byte replaces the old one. A data read in the same cycle as completion counts as reading the old byte first, so no overrun is raised.
- R8: Writing a 0 to a flag bit of the control register clears that flag and writing a 1 leaves it as it is. If a flag is set and cleared in the same cycle, the set wins.
- R9: If the synchronised select input is low while enable and master are set, the mode-fault flag is set, the master bit is cleared and any running master frame is abandoned.
- R10: In slave mode (enable set, master clear), a low synchronised select lets the port shift on edges of the synchronised clock input. It drives the miso output (output enable high) only while selected, and completes after 2·(length code+1) edges.
- R11: The selected status bit is the inverse of the select input after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks receive data as read) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| ss_n_i | input | 1 | Active-low slave-select input |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in for slave |
| mosi_o | output | 1 | Serial data out as master |
| mosi_oe | output | 1 | mosi output enable |
| miso_i | input | 1 | Serial data in for master |
| miso_o | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | miso output enable |

## Verification
Frame completion can land in the same cycle as a software action on the status logic. That action is either a read of the receive register, which decides whether overrun is raised, or a control write that clears the done flag. The bench times a data read and, separately, a control write with zero flag bits to hit the exact completion cycle that R3 predicts. It then expects no overrun, the old byte returned by the read, and done still set. Loopback through an inverter on miso gives the expected received byte for each frame.

// File: rtl/spi_node.sv
module spi_node #(
  parameter int RATE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ss_n_i,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe
);
  logic              en, mst, done_f, wcol_f, ovr_f, modf_f;
  logic              cpol, cpha;
  logic [2:0]        len;
  logic [RATE_W-1:0] rate, div;
  logic [7:0]        sh, sh_nx, rx;
  logic              smp, unread, busy_m, sck_r;
  logic [3:0]        ecnt;
  logic [2:0]        s_sck;
  logic [1:0]        s_mosi, s_ss;

  wire ss_s     = s_ss[1];
  wire wr_ctl   = wr_en && addr == 2'd0;
  wire wr_cfg   = wr_en && addr == 2'd1;
  wire wr_rate  = wr_en && addr == 2'd2;
  wire wr_dat   = wr_en && addr == 2'd3;
  wire rd_dat   = rd_en && addr == 2'd3;
  wire slave_on = en && !mst && !ss_s;
  wire busy     = busy_m || (slave_on && ecnt != 4'd0);
  wire fault    = en && mst && !ss_s;
  wire m_tick   = busy_m && div == rate;
  wire s_edge   = slave_on && (s_sck[1] != s_sck[2]);
  wire edge_ev  = m_tick || s_edge;
  wire last     = ecnt == {len, 1'b1};
  wire fin      = edge_ev && last;
  wire smp_edge = ecnt[0] == cpha;
  wire din      = mst ? miso_i : s_mosi[1];
  wire [7:0] mask = 8'hFF >> (3'd7 - len);

  always_comb begin
    sh_nx = sh;
    if (edge_ev && (smp_edge ? (cpha && last) : !(cpha && ecnt == 4'd0)))
      sh_nx = {sh[6:0], smp_edge ? din : smp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, mst, done_f, wcol_f, ovr_f, modf_f} <= '0;
      {cpha, cpol, len} <= 5'b00111;
      rate <= '0; div <= '0; sh <= '0; rx <= '0; smp <= 1'b0;
      unread <= 1'b0; busy_m <= 1'b0; sck_r <= 1'b0; ecnt <= '0;
      s_sck <= '0; s_mosi <= '0; s_ss <= '1;
    end else begin
      s_sck  <= {s_sck[1:0], sck_i};
      s_mosi <= {s_mosi[0], mosi_i};
      s_ss   <= {s_ss[0], ss_n_i};
      if (!busy_m) sck_r <= cpol;
      if (!busy_m && !slave_on) ecnt <= '0;
      if (wr_ctl) begin
        en <= wdata[0]; mst <= wdata[1];
        done_f <= done_f & wdata[4]; wcol_f <= wcol_f & wdata[5];
        ovr_f  <= ovr_f  & wdata[6]; modf_f <= modf_f & wdata[7];
      end
      if (wr_cfg) {cpha, cpol, len} <= wdata[4:0];
      if (wr_rate) rate <= wdata[RATE_W-1:0];
      if (rd_dat) unread <= 1'b0;
      if (wr_dat && busy) wcol_f <= 1'b1;
      if (wr_dat && !busy) begin
        sh <= wdata;
        if (en && mst) begin
          busy_m <= 1'b1; div <= '0; ecnt <= '0;
        end
      end
      if (busy_m) div <= m_tick ? '0 : div + 1'b1;
      if (edge_ev) begin
        ecnt <= ecnt + 1'b1;
        sh   <= sh_nx;
        if (smp_edge) smp <= din;
        if (busy_m) sck_r <= ~sck_r;
      end
      if (fin) begin
        ecnt <= '0; busy_m <= 1'b0;
        rx <= sh_nx & mask;
        done_f <= 1'b1; unread <= 1'b1;
        if (unread && !rd_dat) ovr_f <= 1'b1;
      end
      if (fault) begin
        mst <= 1'b0; modf_f <= 1'b1; busy_m <= 1'b0; ecnt <= '0;
      end
    end
  end

  assign sck_o   = sck_r;
  assign sck_oe  = en && mst;
  assign mosi_o  = sh[len];
  assign mosi_oe = en && mst;
  assign miso_o  = sh[len];
  assign miso_oe = slave_on;

  always_comb begin
    case (addr)
      2'd0:    rdata = {modf_f, ovr_f, wcol_f, done_f, !ss_s, busy, mst, en};
      2'd1:    rdata = {3'b000, cpha, cpol, len};
      2'd2:    rdata = 8'(rate);
      default: rdata = rx;
    endcase
  end

  a_r6_collision_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && busy) |=> wcol_f);
  a_r9_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (modf_f && !mst && !busy_m));
  a_r3_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> (!busy && unread));
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (done_f && unread));
  a_r7_overrun_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && unread && !rd_dat) |=> ovr_f);
endmodule

// File: tb/spi_node_bench.sv
module spi_node_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;
  assign miso_i = ~mosi_o;

  spi_node u_spi_node (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ss_n_i(ss_n_i), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic pull(input string req);
    logic [7:0] d, e;
    @(negedge clk); addr = 2'd3; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
    e = exp_q.pop_front();
    chk(d == e, req, d, e);
  endtask

  task automatic ext_master(input logic [7:0] b, input int n, input bit pol,
                            input bit pha, output logic [7:0] got);
    got = 8'd0;
    for (int i = n - 1; i >= 0; i--) begin
      if (!pha) begin
        mosi_i = b[i]; waitc(6);
        sck_i = ~pol; got[i] = miso_o; waitc(6);
        sck_i = pol;
      end else begin
        sck_i = ~pol; mosi_i = b[i]; waitc(6);
        sck_i = pol; got[i] = miso_o; waitc(6);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d, g;
    waitc(3); rst_n = 1'b1; waitc(1);
    peek(0, d); chk(d == 8'h00, "R1 ctl", d, 8'h00);
    peek(1, d); chk(d == 8'h07, "R1 cfg", d, 8'h07);
    peek(2, d); chk(d == 8'h00, "R1 rate", d, 8'h00);
    chk({sck_oe, mosi_oe, miso_oe} == 3'b000, "R1 enables", {sck_oe, mosi_oe, miso_oe}, 0);

    wr(0, 8'h03);
    peek(0, d); chk(d == 8'h03, "R2 ctl readback", d, 8'h03);
    wr(1, 8'h07); wr(2, 8'h00);
    peek(1, d); chk(d == 8'h07, "R2 cfg readback", d, 8'h07);
    chk(sck_o == 1'b0, "R4 idle low", sck_o, 0);
    // R3: rate 0, 8 bits -> 16 cycles
    wr(3, 8'hA5); push(8'h5A);
    waitc(1); chk(sck_o == 1'b1, "R3 first toggle", sck_o, 1);
    waitc(14); peek(0, d); chk(d[2] && !d[4], "R3 busy before end", d, 8'h07);
    waitc(1); peek(0, d); chk(!d[2] && d[4], "R3 done on time", d, 8'h13);
    chk(sck_o == 1'b0, "R4 back to idle", sck_o, 0);
    pull("R5 mode0 8 bits");

    // R3/R4: rate 3, cpol 1, cpha 1 -> 64 cycles
    wr(2, 8'h03); wr(1, 8'h1F);
    waitc(1); chk(sck_o == 1'b1, "R4 idle high", sck_o, 1);
    wr(3, 8'h3C); push(8'hC3);
    waitc(3); chk(sck_o == 1'b1, "R3 still idle at rate", sck_o, 1);
    waitc(1); chk(sck_o == 1'b0, "R3 toggle after rate+1", sck_o, 0);
    waitc(59); peek(0, d); chk(d[2], "R3 busy at 63", d, 8'h07);
    waitc(1); peek(0, d); chk(d[4] && !d[2], "R3 done at 64", d, 8'h13);
    chk(sck_o == 1'b1, "R4 ends high", sck_o, 1);
    pull("R5 mode3 8 bits");
    wr(0, 8'h03); peek(0, d); chk(d[4] == 1'b0, "R8 clear done", d, 8'h03);

    // R5: 3-bit frame, cpha 1 cpol 0, rate 1 -> 12 cycles
    wr(2, 8'h01); wr(1, 8'h12);
    wr(3, 8'h6D); push(8'h02);
    waitc(11); peek(0, d); chk(d[2], "R5 short busy", d, 8'h07);
    waitc(1); peek(0, d); chk(d[4], "R5 short done", d, 8'h13);
    pull("R5 3-bit frame");

    // R7: two 1-bit frames, no read between
    wr(0, 8'h03); wr(2, 8'h00); wr(1, 8'h08);
    wr(3, 8'h00); waitc(6);
    wr(3, 8'h01); push(8'h00); waitc(6);
    peek(0, d); chk(d[6] == 1'b1, "R7 overrun set", d, 8'h53);
    pull("R7 newest byte kept");

    // R6: collision during frame
    wr(0, 8'h03); wr(1, 8'h07);
    wr(3, 8'h0F); push(8'hF0);
    wr(3, 8'hFF);
    peek(0, d); chk(d[5] && d[2], "R6 collision flag", d, 8'h27);
    waitc(20); pull("R6 frame unchanged");

    // R7: read at exact completion cycle
    wr(0, 8'h03);
    wr(3, 8'h11); waitc(20);
    wr(3, 8'h22); waitc(14);
    @(negedge clk); addr = 2'd3; rd_en = 1'b1; #1; d = rdata;
    chk(d == 8'hEE, "R7 coincident read old byte", d, 8'hEE);
    @(negedge clk); rd_en = 1'b0;
    peek(0, d); chk(d[6] == 1'b0 && d[4], "R7 no overrun on coincident read", d, 8'h13);
    push(8'hDD); pull("R7 new byte after coincident read");

    // R8: clear at exact completion cycle
    wr(0, 8'h03); peek(0, d); chk(d[4] == 1'b0, "R8 done cleared", d, 8'h03);
    wr(3, 8'h44); push(8'hBB); waitc(14);
    @(negedge clk); addr = 2'd0; wdata = 8'h03; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    peek(0, d); chk(d[4] == 1'b1, "R8 set wins", d, 8'h13);
    pull("R8 byte");

    // R9: mode fault mid-frame
    wr(0, 8'h03); wr(2, 8'h03);
    wr(3, 8'h55); waitc(5);
    ss_n_i = 1'b0; waitc(3);
    peek(0, d); chk(d == 8'h89, "R9 fault state", d, 8'h89);
    chk(sck_oe == 1'b0, "R9 clock released", sck_oe, 0);
    ss_n_i = 1'b1; waitc(3);
    peek(0, d); chk(d[3] == 1'b0, "R11 deselected", d, 8'h81);

    // R10: slave mode 0, 8 bits
    wr(0, 8'h01); wr(1, 8'h07); sck_i = 1'b0;
    wr(3, 8'h96);
    chk(miso_oe == 1'b0, "R10 miso off unselected", miso_oe, 0);
    ss_n_i = 1'b0; waitc(1);
    peek(0, d); chk(d[3] == 1'b0, "R11 sync delay", d, 8'h01);
    waitc(3);
    peek(0, d); chk(d[3] == 1'b1, "R11 selected", d, 8'h09);
    chk(miso_oe == 1'b1, "R10 miso driven", miso_oe, 1);
    ext_master(8'h3A, 8, 1'b0, 1'b0, g); waitc(8);
    chk(g == 8'h96, "R10 slave sends", g, 8'h96);
    peek(0, d); chk(d[4] && !d[2], "R10 slave done", d, 8'h19);
    push(8'h3A); pull("R10 slave receives");
    ss_n_i = 1'b1; waitc(4);

    // R10: slave mode 3, 5 bits
    wr(0, 8'h01); wr(1, 8'h1C); sck_i = 1'b1;
    wr(3, 8'h15);
    ss_n_i = 1'b0; waitc(4);
    ext_master(8'h0B, 5, 1'b1, 1'b1, g); waitc(8);
    chk(g == 8'h15, "R10 slave mode3 sends", g, 8'h15);
    peek(0, d); chk(d[4] && !d[6], "R10 slave mode3 done", d, 8'h19);
    push(8'h0B); pull("R10 slave mode3 receives");
    ss_n_i = 1'b1; waitc(4);
    chk(miso_oe == 1'b0, "R10 miso released", miso_oe, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule